// File: doc/BRIEF.md
# Sleep Wake-Up Interrupt Sequencer

This controller sits beside a small processor core and decides when the core's instruction clock runs. While running, it divides the oscillator clock into four one-hot phase strobes per instruction cycle. When the core decodes a sleep instruction on the last phase of a cycle, the sequencer stops the phases and drops the run enable. It then waits for a rising edge on the external interrupt pin.

A pin edge always sets a sticky interrupt flag. The flag wakes the block only when the pin interrupt enable is set. In crystal or resonator mode the sequencer then holds the core for a parameterised oscillator start-up interval. In RC mode it resumes at once. The core always finishes the instruction that was prefetched before sleep. If the global interrupt enable was set at wake-up, a dummy cycle follows, during which the block loads the program counter with the interrupt vector and clears the global enable. Otherwise execution carries on in-line.

Top module: `sleep_wake_seq`

## Requirements
- R1: While `rst_n` is low and in the first sample after it rises, `run_en` is 1, `q_phase` is 4'b0001 (Q1), `int_flag` is 0 and `pc_load` is 0.
- R2: While running, `q_phase` is one-hot and steps Q1=4'b0001, Q2=4'b0010, Q3=4'b0100, Q4=4'b1000, then back to Q1, one step per clock.
- R3: `sleep_exec` high during Q4 while `run_en` is 1 stops the block at the next clock: `run_en` 0 and `q_phase` 4'b0000. `sleep_exec` in any other phase is ignored.
- R4: A rising edge on `int_pin` sets `int_flag` at the next clock. The flag stays set until `int_flag_clr`, and an edge in the same cycle as a clear wins.
- R5: While `pin_ie` is 0, a pin edge sets the flag but does not wake the block. Raising `pin_ie` later wakes it from the pending flag.
- R6: With `osc_rc` 0, `run_en` returns `OST_CYCLES`+1 clocks after `int_flag` is first seen high.
- R7: With `osc_rc` 1, `run_en` returns one clock after `int_flag` is first seen high.
- R8: The first cycle after wake-up starts at Q1 with `run_en` 1, with no program-counter load.
- R9: If `gie` was 1 at wake-up, the second instruction cycle is a dummy cycle. `run_en` is 0 for its four clocks. On its Q1, `pc_load` and `gie_clr` pulse for one clock, with `pc_vector` equal to `VECTOR` (default 4). `run_en` returns on the next Q1.
- R10: If `gie` was 0 at wake-up, `pc_load` stays 0 and `run_en` stays 1 through the cycles that follow.
- R11: If `int_flag` and `pin_ie` are both 1 when a sleep is decoded, the sleep is a no-op and the phases keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| sleep_exec | input | 1 | Core decoded a sleep instruction |
| int_pin | input | 1 | External interrupt pin |
| gie | input | 1 | Global interrupt enable |
| pin_ie | input | 1 | Pin interrupt enable |
| osc_rc | input | 1 | 1 = RC mode, start-up wait skipped |
| int_flag_clr | input | 1 | Clears the interrupt flag |
| q_phase | output | 4 | One-hot phase strobes Q1..Q4 |
| run_en | output | 1 | Core may execute this cycle |
| pc_load | output | 1 | Load program counter with vector |
| pc_vector | output | PC_W | Interrupt vector address |
| gie_clr | output | 1 | Clears the global interrupt enable |
| int_flag | output | 1 | Pin interrupt flag |

## Verification
Two functions can fall in the same cycle: a sleep decode and a pending, enabled pin flag, which must turn the sleep into a no-op. The bench provokes this by setting the flag while running and then issuing `sleep_exec` on Q4. It judges the outcome by requiring Q1 and `run_en` at the next sample. Flag set and flag clear also collide: the bench pulses the pin in the same cycle as `int_flag_clr` and expects the flag to stay set. Each wake is swept over both oscillator modes and both global-enable values, with the start-up latency counted clock by clock.

// File: rtl/sws_pkg.sv
package sws_pkg;
    typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_OST} sws_state_e;
    typedef enum logic [1:0] {POST_NONE, POST_FIRST, POST_DUMMY} sws_post_e;

    typedef struct packed {
        sws_state_e state;
        sws_post_e  post;
        logic [1:0] ph;
        logic       take_vec;
    } sws_regs_t;

    localparam logic [1:0] PH_Q1 = 2'd0;
    localparam logic [1:0] PH_Q4 = 2'd3;
endpackage

// File: rtl/sws_pin_flag.sv
module sws_pin_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic clr,
    output logic flag
);
    logic prev_d, prev_q;
    logic flag_d, flag_q;
    logic rise;

    always_comb begin
        rise   = pin & ~prev_q;
        prev_d = pin;
        flag_d = rise | (flag_q & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin && !prev_q) |=> flag_q);
    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/sws_ost_timer.sv
module sws_ost_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run ? cnt_q + CW'(1) : '0;
        done  = run && (cnt_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6
    ost_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !run);
    // R6
    ost_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> cnt_q == $past(cnt_q) + CW'(1));
endmodule

// File: rtl/sleep_wake_seq.sv
module sleep_wake_seq
    import sws_pkg::*;
#(
    parameter int OST_CYCLES = 1024,
    parameter int PC_W       = 13,
    parameter int VECTOR     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_exec,
    input  logic            int_pin,
    input  logic            gie,
    input  logic            pin_ie,
    input  logic            osc_rc,
    input  logic            int_flag_clr,
    output logic [3:0]      q_phase,
    output logic            run_en,
    output logic            pc_load,
    output logic [PC_W-1:0] pc_vector,
    output logic            gie_clr,
    output logic            int_flag
);
    localparam logic [PC_W-1:0] VEC_ADDR = PC_W'(VECTOR);

    sws_regs_t r_d, r_q;
    logic flag_w, wake_req, ost_run, ost_done;

    sws_pin_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (int_pin),
        .clr  (int_flag_clr),
        .flag (flag_w)
    );

    assign ost_run = (r_q.state == ST_OST);

    sws_ost_timer #(.LIMIT(OST_CYCLES)) u_ost (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ost_run),
        .done (ost_done)
    );

    always_comb begin
        r_d      = r_q;
        wake_req = flag_w & pin_ie;
        case (r_q.state)
            ST_RUN: begin
                r_d.ph = r_q.ph + 2'd1;
                if (r_q.ph == PH_Q4) begin
                    if (r_q.post == POST_FIRST)      r_d.post = POST_DUMMY;
                    else if (r_q.post == POST_DUMMY) r_d.post = POST_NONE;
                end
                if (run_en && sleep_exec && r_q.ph == PH_Q4 && !wake_req) begin
                    r_d.state = ST_SLEEP;
                    r_d.ph    = PH_Q1;
                    r_d.post  = POST_NONE;
                end
            end
            ST_SLEEP: begin
                if (wake_req) begin
                    r_d.take_vec = gie;
                    r_d.ph       = PH_Q1;
                    if (osc_rc) begin
                        r_d.state = ST_RUN;
                        r_d.post  = gie ? POST_FIRST : POST_NONE;
                    end else begin
                        r_d.state = ST_OST;
                    end
                end
            end
            ST_OST: begin
                if (ost_done) begin
                    r_d.state = ST_RUN;
                    r_d.ph    = PH_Q1;
                    r_d.post  = r_q.take_vec ? POST_FIRST : POST_NONE;
                end
            end
            default: r_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_RUN;
            r_q.post     <= POST_NONE;
            r_q.ph       <= PH_Q1;
            r_q.take_vec <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        q_phase   = (r_q.state == ST_RUN) ? (4'b0001 << r_q.ph) : 4'b0000;
        run_en    = (r_q.state == ST_RUN) && (r_q.post != POST_DUMMY);
        pc_load   = (r_q.state == ST_RUN) && (r_q.post == POST_DUMMY) && (r_q.ph == PH_Q1);
        gie_clr   = pc_load;
        pc_vector = VEC_ADDR;
        int_flag  = flag_w;
    end

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN && r_d.state == ST_RUN) |=> r_q.ph == $past(r_q.ph) + 2'd1);
    // R3
    sleep_at_q4_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SLEEP && $past(r_q.state) == ST_RUN) |-> $past(r_q.ph) == PH_Q4);
    // R7
    rc_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_OST && $past(r_q.state) == ST_SLEEP) |-> !$past(osc_rc));
    // R9
    dummy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.post == POST_DUMMY && r_q.ph == PH_Q4) |=> r_q.post == POST_NONE);
    // R11
    noop_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN && run_en && sleep_exec && r_q.ph == PH_Q4 && flag_w && pin_ie)
        |=> r_q.state == ST_RUN);
endmodule

// File: tb/test_sleep_wake_seq.sv
module test_sleep_wake_seq;
    localparam int OST = 1024;
    localparam int PCW = 13;

    logic clk = 1'b0;
    logic rst_n, sleep_exec, int_pin, gie, pin_ie, osc_rc, int_flag_clr;
    logic [3:0] q_phase;
    logic run_en, pc_load, gie_clr, int_flag;
    logic [PCW-1:0] pc_vector;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sleep_wake_seq #(.OST_CYCLES(OST), .PC_W(PCW), .VECTOR(4)) i_sleep_wake_seq (
        .clk(clk), .rst_n(rst_n), .sleep_exec(sleep_exec), .int_pin(int_pin),
        .gie(gie), .pin_ie(pin_ie), .osc_rc(osc_rc), .int_flag_clr(int_flag_clr),
        .q_phase(q_phase), .run_en(run_en), .pc_load(pc_load), .pc_vector(pc_vector),
        .gie_clr(gie_clr), .int_flag(int_flag)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic to_q4();
        int guard = 0;
        while (q_phase != 4'b1000 && guard < 8) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic go_sleep();
        to_q4();
        sleep_exec = 1'b1;
        @(negedge clk);
        sleep_exec = 1'b0;
        chk("R3 sleep run_en", {31'd0, run_en}, 32'd0);
        chk("R3 sleep q_phase", {28'd0, q_phase}, 32'd0);
    endtask

    task automatic wake_and_check(input logic rc, input logic g);
        int n = 0;
        osc_rc = rc; gie = g; pin_ie = 1'b1;
        int_pin = 1'b1;
        @(negedge clk);
        int_pin = 1'b0;
        chk("R4 flag set by edge", {31'd0, int_flag}, 32'd1);
        chk("R6 asleep at flag", {31'd0, run_en}, 32'd0);
        while (!run_en && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (rc) chk("R7 rc latency", n, 32'd1);
        else    chk("R6 ost latency", n, OST + 1);
        chk("R8 resume phase", {28'd0, q_phase}, 32'd1);
        chk("R8 resume no load", {31'd0, pc_load}, 32'd0);
        chk("R4 flag held", {31'd0, int_flag}, 32'd1);
        int_flag_clr = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            int_flag_clr = 1'b0;
            if (g) begin
                if (k == 4) begin
                    chk("R9 pc_load", {31'd0, pc_load}, 32'd1);
                    chk("R9 gie_clr", {31'd0, gie_clr}, 32'd1);
                    chk("R9 vector", {19'd0, pc_vector}, 32'd4);
                end else begin
                    chk("R9 no extra load", {31'd0, pc_load}, 32'd0);
                end
                chk("R9 run_en", {31'd0, run_en}, (k >= 4 && k <= 7) ? 32'd0 : 32'd1);
            end else begin
                chk("R10 no load", {31'd0, pc_load}, 32'd0);
                chk("R10 run_en", {31'd0, run_en}, 32'd1);
            end
        end
        chk("R4 flag cleared", {31'd0, int_flag}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sleep_exec = 1'b0; int_pin = 1'b0; gie = 1'b0;
        pin_ie = 1'b0; osc_rc = 1'b0; int_flag_clr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset run_en", {31'd0, run_en}, 32'd1);
        chk("R1 reset phase", {28'd0, q_phase}, 32'd1);
        chk("R1 reset flag", {31'd0, int_flag}, 32'd0);
        chk("R1 reset pc_load", {31'd0, pc_load}, 32'd0);
        rst_n = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            chk("R2 phase rotation", {28'd0, q_phase}, 32'd1 << (k % 4));
        end

        // R3: decode outside Q4 is ignored
        while (q_phase != 4'b0010) @(negedge clk);
        sleep_exec = 1'b1;
        @(negedge clk);
        sleep_exec = 1'b0;
        chk("R3 non-Q4 ignored run_en", {31'd0, run_en}, 32'd1);
        chk("R3 non-Q4 ignored phase", {28'd0, q_phase}, 32'd4);

        // sweep oscillator mode x global enable
        for (int m = 0; m < 4; m++) begin
            go_sleep();
            wake_and_check(m[1], m[0]);
        end

        // R5: wake needs the pin enable
        go_sleep();
        pin_ie = 1'b0; osc_rc = 1'b1; gie = 1'b0;
        int_pin = 1'b1;
        @(negedge clk);
        int_pin = 1'b0;
        chk("R5 flag set without enable", {31'd0, int_flag}, 32'd1);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (k % 5 == 0) chk("R5 stays asleep", {31'd0, run_en}, 32'd0);
        end
        pin_ie = 1'b1;
        @(negedge clk);
        chk("R5 pending flag wakes", {31'd0, run_en}, 32'd1);
        int_flag_clr = 1'b1;
        @(negedge clk);
        int_flag_clr = 1'b0;

        // R4: edge beats a simultaneous clear
        int_pin = 1'b1; int_flag_clr = 1'b1;
        @(negedge clk);
        int_pin = 1'b0; int_flag_clr = 1'b0;
        chk("R4 set wins over clear", {31'd0, int_flag}, 32'd1);

        // R11: sleep with pending enabled flag is a no-op
        to_q4();
        sleep_exec = 1'b1;
        @(negedge clk);
        sleep_exec = 1'b0;
        chk("R11 no-op run_en", {31'd0, run_en}, 32'd1);
        chk("R11 no-op phase", {28'd0, q_phase}, 32'd1);
        @(negedge clk);
        chk("R11 phases continue", {28'd0, q_phase}, 32'd2);
        int_flag_clr = 1'b1;
        @(negedge clk);
        int_flag_clr = 1'b0;
        @(negedge clk);
        chk("R4 clear works", {31'd0, int_flag}, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule